// File: doc/BRIEF.md
# Repeat-Sweep ADC Channel Sequencer

This block is the digital control for a multi-channel successive-approximation converter that runs in an endless sweep. Software raises a start level. The sequencer then converts channel 0, then channel 1, and so on up to the last channel of the chosen group. After the last channel it wraps back to channel 0. It keeps sweeping until software drops the start level. Each finished conversion is stored in a result register that belongs to the channel just converted. No completion interrupt exists in this mode.

A divided conversion tick paces each channel. The tick is the system clock divided by 4, by 2 or by 1. A channel takes a fixed number of ticks, set by the resolution and the sample-and-hold setting. The first part of that budget is sampling time. The rest is one trial per result bit, MSB first. Each trial is judged by a one-bit comparator input. The block drives the channel select, the trial code, the resolution and the sample-and-hold enable to the analog side. For test, it gives a one-cycle done strobe together with the index of the channel that finished.

Top module: `adc_sweep_seq`

## Requirements
- R1: While idle, start_i high at a clock edge makes busy_o high after that edge, with ch_o = 0 as the first channel.
- R2: When a channel finishes, its result is written to slot ch of result_o (bits ch*10 +: 10). The result is the SAR code decided MSB first, where cmp_i = 1 keeps the trial bit (input at or above the trial code).
- R3: Channels run in ascending order from 0 to the last channel of the group, then wrap to 0. grp_i codes 0, 1, 2 and 3 select channels 0–1, 0–3, 0–5 and 0–7.
- R4: The sweep repeats with no gap and no software action for as long as start_i stays high.
- R5: One channel lasts 28 ticks (8-bit, sample-and-hold on), 33 ticks (10-bit, on), 49 ticks (8-bit, off) or 59 ticks (10-bit, off). res10_i = 1 selects 10 bits and sh_i = 1 turns sample-and-hold on.
- R6: div_i selects the tick rate: code 0 is clock/4, code 1 is clock/2, and codes 2 and 3 are clock/1. One channel therefore lasts ticks × divisor clock cycles.
- R7: start_i low while busy returns the block to idle after the next edge. The channel in progress writes no result and gives no done strobe. A later start begins again at channel 0.
- R8: trial_o is 0 during sampling. The first trial presents the MSB alone (0x200 at 10 bits, 0x080 at 8 bits). An 8-bit result occupies bits 7:0 of its slot and bits 9:8 are 0.
- R9: div_i, res10_i, sh_i and grp_i are captured at start. Changes to them during a sweep have no effect. sh_en_o and res10_o show the captured values while busy.
- R10: done_o is a one-cycle pulse in the cycle after a channel finishes. done_ch_o gives the index of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start level; high runs the sweep, low stops it |
| div_i | input | 2 | Tick divider select (0:/4, 1:/2, 2–3:/1) |
| res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_i | input | 1 | 1 = sample-and-hold enabled |
| grp_i | input | 2 | Sweep group: last channel = 2*grp_i+1 |
| cmp_i | input | 1 | Comparator decision for the current trial |
| busy_o | output | 1 | Sweep running |
| ch_o | output | 3 | Channel select to the analog mux |
| trial_o | output | 10 | SAR trial code to the DAC |
| sh_en_o | output | 1 | Captured sample-and-hold enable |
| res10_o | output | 1 | Captured resolution |
| done_o | output | 1 | One-cycle channel-finished strobe |
| done_ch_o | output | 3 | Index of the finished channel |
| result_o | output | 80 | Eight 10-bit per-channel result registers |

## Verification
The bench builds the block with its default parameters: eight channels, 10-bit results and a 6-bit tick counter. This lets every group size and both resolutions be exercised. Four sweeps use a different divider code, resolution, sample-and-hold setting and group each. Together they cover all four channel lengths and the wrap point of every group, and they count exact clock cycles between strobes. A behavioural comparator model gives each channel a fixed analog level, so every result slot has a known value. This includes the all-ones and all-zeros codes and the clipping of 8-bit results.

// File: rtl/adc_sweep_pkg.sv
package adc_sweep_pkg;
  localparam int unsigned TICKS_SH_8   = 28;
  localparam int unsigned TICKS_SH_10  = 33;
  localparam int unsigned TICKS_NSH_8  = 49;
  localparam int unsigned TICKS_NSH_10 = 59;

  typedef struct packed {
    logic [1:0] div;
    logic       res10;
    logic       sh;
    logic [1:0] grp;
  } sweep_cfg_t;

  function automatic int unsigned chan_ticks(logic res10, logic sh);
    case ({sh, res10})
      2'b11:   return TICKS_SH_10;
      2'b10:   return TICKS_SH_8;
      2'b01:   return TICKS_NSH_10;
      default: return TICKS_NSH_8;
    endcase
  endfunction
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       ce_o
);
  logic [1:0] cnt_q, lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = 2'd3;
      2'd1:    lim = 2'd1;
      default: lim = 2'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == lim)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 2'd1;
  end

  assign ce_o = run_i && (cnt_q == lim);

  // R6
  div4_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i == 2'd0 && ce_o) |=> !ce_o);
  // R6
  div1_every_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i[1] && $past(run_i)) |-> ce_o);
endmodule

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ce_i,
  input  logic             res10_i,
  input  logic [CNT_W-1:0] budget_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             fin_o,
  output logic [RES_W-1:0] fin_val_o
);
  logic [CNT_W-1:0] cnt_q, nbits, samp_last;
  logic [RES_W-1:0] acc_q, mask_q, msb_mask;

  assign nbits     = res10_i ? CNT_W'(RES_W) : CNT_W'(RES_W - 2);
  assign samp_last = budget_i - nbits - CNT_W'(1);
  assign msb_mask  = res10_i ? (RES_W'(1) << (RES_W - 1)) : (RES_W'(1) << (RES_W - 3));

  assign fin_o     = run_i && ce_i && (cnt_q == budget_i - CNT_W'(1));
  assign fin_val_o = acc_q | (cmp_i ? mask_q : '0);
  assign trial_o   = acc_q | mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; acc_q <= '0; mask_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0; acc_q <= '0; mask_q <= '0;
    end else if (ce_i) begin
      if (fin_o) begin
        cnt_q <= '0; acc_q <= '0; mask_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == samp_last) begin
          mask_q <= msb_mask;            // sampling over, first trial
        end else if (mask_q != '0) begin
          if (cmp_i) acc_q <= acc_q | mask_q;
          mask_q <= mask_q >> 1;
        end
      end
    end
  end

  // R8
  last_trial_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> mask_q[0]);
  // R8
  mask_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
  import adc_sweep_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  parameter int unsigned CNT_W = 6,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           div_i,
  input  logic                 res10_i,
  input  logic                 sh_i,
  input  logic [1:0]           grp_i,
  input  logic                 cmp_i,
  output logic                 busy_o,
  output logic [CH_W-1:0]      ch_o,
  output logic [RES_W-1:0]     trial_o,
  output logic                 sh_en_o,
  output logic                 res10_o,
  output logic                 done_o,
  output logic [CH_W-1:0]      done_ch_o,
  output logic [NCH*RES_W-1:0] result_o
);
  sweep_cfg_t       cfg_q;
  logic             busy_q, run, ce, fin;
  logic [CH_W-1:0]  ch_q, last_ch;
  logic [CNT_W-1:0] budget;
  logic [RES_W-1:0] fin_val;

  assign run     = busy_q && start_i;
  assign last_ch = CH_W'({cfg_q.grp, 1'b1});
  assign budget  = CNT_W'(chan_ticks(cfg_q.res10, cfg_q.sh));

  adc_tick_div u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .sel_i(cfg_q.div), .ce_o(ce)
  );

  adc_sar_step #(.RES_W(RES_W), .CNT_W(CNT_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .ce_i     (ce),
    .res10_i  (cfg_q.res10),
    .budget_i (budget),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .fin_o    (fin),
    .fin_val_o(fin_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; ch_q <= '0; cfg_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        cfg_q  <= '{div: div_i, res10: res10_i, sh: sh_i, grp: grp_i};
      end
    end else if (!start_i) begin
      busy_q <= 1'b0;                    // abort, partial result dropped
      ch_q   <= '0;
    end else if (fin) begin
      ch_q <= (ch_q == last_ch) ? '0 : ch_q + CH_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; done_ch_o <= '0;
    end else begin
      done_o    <= fin;
      done_ch_o <= ch_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         result_o[g*RES_W +: RES_W] <= '0;
      else if (fin && ch_q == CH_W'(g))    result_o[g*RES_W +: RES_W] <= fin_val;
    end
  end

  assign busy_o  = busy_q;
  assign ch_o    = ch_q;
  assign sh_en_o = busy_q && cfg_q.sh;
  assign res10_o = busy_q && cfg_q.res10;

  // R3
  ch_in_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ch_q <= last_ch);
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && busy_q && done_ch_o == last_ch) |-> ch_q == '0);
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i) |=> (!busy_q && !done_o));
  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));
endmodule

// File: tb/adc_sweep_seq_tb.sv
`timescale 1ns/1ps
module adc_sweep_seq_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 1'b0, res10 = 1'b0, sh = 1'b0, cmp;
  logic [1:0] dv = 2'd0, grp = 2'd0;
  logic       busy, sh_en, r10_o, done;
  logic [2:0] ch, done_ch;
  logic [9:0] trial;
  logic [79:0] res;
  logic [9:0] ana [8];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_sweep_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(dv), .res10_i(res10),
    .sh_i(sh), .grp_i(grp), .cmp_i(cmp), .busy_o(busy), .ch_o(ch), .trial_o(trial),
    .sh_en_o(sh_en), .res10_o(r10_o), .done_o(done), .done_ch_o(done_ch), .result_o(res)
  );

  always_comb cmp = (trial <= ana[ch]);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks(input logic r10, input logic s);
    if (s) return r10 ? 33 : 28;
    return r10 ? 59 : 49;
  endfunction

  function automatic int divf(input logic [1:0] d);
    return (d == 2'd0) ? 4 : (d == 2'd1) ? 2 : 1;
  endfunction

  function automatic int expv(input int g, input logic r10);
    if (r10) return int'(ana[g]);
    return (ana[g] > 10'd255) ? 255 : int'(ana[g]);
  endfunction

  // R1 R2 R3 R4 R5 R6 R10
  task automatic run_sweep(input logic [1:0] d, input logic r10, input logic s,
                           input logic [1:0] g, input int n);
    int per = ticks(r10, s) * divf(d);
    int nch = 2 * int'(g) + 2;
    @(negedge clk);
    dv = d; res10 = r10; sh = s; grp = g; start = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 1);
    chk("R1 first channel", ch, 0);
    for (int k = 0; k < n; k++) begin
      int w = (k == 0) ? 1 : 0;
      do begin @(negedge clk); w++; end while (!done && w < 20000);
      chk("R5 R6 channel period", w, (k == 0) ? per + 1 : per);
      chk("R3 R4 channel order", done_ch, k % nch);
      chk("R2 R8 result slot", res[(k % nch)*10 +: 10], expv(k % nch, r10));
      chk("R9 captured cfg", {sh_en, r10_o}, {s, r10});
    end
    start = 1'b0;
    @(negedge clk);
    chk("R10 single-cycle strobe", done, 0);
    chk("R7 stop", busy, 0);
  endtask

  // R7
  task automatic abort_test();
    logic [79:0] snap;
    bit seen = 0;
    @(negedge clk);
    dv = 2'd2; res10 = 1'b1; sh = 1'b1; grp = 2'd3;
    for (int g = 0; g < 8; g++) ana[g] = ~ana[g];
    start = 1'b1;
    repeat (25) @(negedge clk);
    snap = res;
    start = 1'b0;
    @(negedge clk);
    chk("R7 idle after abort", busy, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk("R7 no strobe after abort", seen, 0);
    chk("R7 result kept", (res == snap), 1);
    for (int g = 0; g < 8; g++) ana[g] = ~ana[g];
    run_sweep(2'd2, 1'b1, 1'b1, 2'd3, 1);
  endtask

  // R8
  task automatic trial_test();
    @(negedge clk);
    dv = 2'd2; res10 = 1'b0; sh = 1'b1; grp = 2'd0; start = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 trial zero while sampling", trial, 0);
    @(negedge clk);
    chk("R8 first trial is MSB", trial, 10'h080);
    start = 1'b0;
    @(negedge clk);
    chk("R7 idle", busy, 0);
  endtask

  // R9
  task automatic cfg_ignore_test();
    @(negedge clk);
    dv = 2'd0; res10 = 1'b1; sh = 1'b1; grp = 2'd0; start = 1'b1;
    repeat (3) @(negedge clk);
    dv = 2'd2; res10 = 1'b0; sh = 1'b0; grp = 2'd3;
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 3 : 0;
      do begin @(negedge clk); w++; end while (!done && w < 20000);
      chk("R9 period unchanged", w, (k == 0) ? 33*4 + 1 : 33*4);
      chk("R9 group unchanged", done_ch, k % 2);
      chk("R9 resolution unchanged", res[(k % 2)*10 +: 10], expv(k % 2, 1'b1));
    end
    chk("R9 outputs show captured cfg", {sh_en, r10_o}, 2'b11);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    ana[0] = 10'h3FF; ana[1] = 10'h000; ana[2] = 10'h155; ana[3] = 10'h2AA;
    ana[4] = 10'h0C3; ana[5] = 10'h200; ana[6] = 10'h1FF; ana[7] = 10'h07E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R2 reset results", (res == '0), 1);
    chk("R10 reset strobe", done, 0);
    run_sweep(2'd2, 1'b1, 1'b1, 2'd1, 8);
    run_sweep(2'd0, 1'b0, 1'b0, 2'd3, 9);
    run_sweep(2'd1, 1'b1, 1'b0, 2'd2, 7);
    run_sweep(2'd3, 1'b0, 1'b1, 2'd0, 5);
    trial_test();
    abort_test();
    cfg_ignore_test();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule